// File: doc/BRIEF.md
# Isolated Digital I/O Port Controller

This block is the register front end of a sixteen-output, sixteen-input digital I/O card. A host reaches it through a small synchronous byte bus with an eight-address window. Two byte-wide output latches drive the output lines. The input lines pass through a two-flop synchronizer and can be read back as two bytes.

Any change on any input line can raise a single level interrupt request. This works on rising and falling edges alike. The interrupt logic has no control register. Reading the control address arms it, and writing the control address disarms it. Writing the low input-data address acknowledges a pending request.

The interrupt logic is a three-state machine:
- `ST_OFF`: disarmed. It is left by `arm` (a read of offset 2) and goes to `ST_ARMED`.
- `ST_ARMED`: armed, nothing pending. It is left by `change` and goes to `ST_PENDING`.
- `ST_PENDING`: request raised. It is left by `ack` (a write of offset 1 with no change in the same cycle) and goes back to `ST_ARMED`.

The `disarm` transition (a write of offset 2) leads from every state to `ST_OFF`. It takes priority over everything else. The request output is high exactly while the machine is in `ST_PENDING`.

Top module: `dio_port_ctrl`

## Requirements
- R1: After reset the output lines are all ones (16'hFFFF), the interrupt request is low, interrupts are disarmed and the read data bus is zero.
- R2: A write strobe to offset 0 loads output lines 7:0 from the write data, and a write strobe to offset 4 loads lines 15:8. The other byte is unchanged. The new value shows on the outputs one clock after the strobe.
- R3: A read strobe to offset 1 returns synchronized input lines 7:0, and a read strobe to offset 5 returns lines 15:8. Read data is registered: it is valid in the cycle after the strobe and is zero in every other cycle.
- R4: Reads of offsets 0, 2, 3, 4, 6 and 7 return zero. Writes to offsets 3, 5, 6 and 7 change neither the outputs nor the interrupt request.
- R5: Any read strobe to offset 2 arms interrupt generation (`ST_OFF` to `ST_ARMED`). A read of offset 2 while already armed leaves a pending request in place.
- R6: While armed, a rising or falling change on any input line raises the interrupt request, and the request stays high until it is cleared. The request goes high on the third rising clock edge after the pin changes: two synchronizer flops, then the state register.
- R7: A write strobe to offset 1 clears a pending request whatever the data (`ST_PENDING` to `ST_ARMED`). Interrupts stay armed afterwards.
- R8: A write strobe to offset 2 disarms interrupts whatever the data and drops any pending request. While disarmed, input changes do not raise the request.
- R9: If an input change is detected in the same cycle as an acknowledge write, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Raw input lines (asynchronous) |
| drive_out | output | 16 | Output line levels |
| irq_req | output | 1 | Level interrupt request |

## Verification
The bench targets the priority corner where an input change and an acknowledge write arrive in the same cycle. A design that lets the acknowledge win there would lose an interrupt and show the request low.

It also times the request edge against the synchronizer depth. A design with one flop too few or too many would show the request a cycle early or late.

Changes made while disarmed must leave the request low. A design that records them would fire as soon as the host re-arms.

Writes to the spare offsets and to the high input byte must leave the latches untouched. A design with loose address decode would corrupt an output byte or clear a pending request.

// File: rtl/dio_pkg.sv
package dio_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2
    } irq_state_t;

    // Sub-offset within one four-byte lane group: lane k owns offsets 4k..4k+3
    localparam logic [1:0] SUB_OUT  = 2'd0;
    localparam logic [1:0] SUB_IN   = 2'd1;
    localparam logic [1:0] SUB_CTRL = 2'd2;

    typedef struct packed {
        logic arm;
        logic disarm;
        logic ack;
    } irq_cmd_t;

endpackage

// File: rtl/dio_bus_decode.sv
module dio_bus_decode
    import dio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [LANES*DATA_W-1:0]   in_sync,
    output logic [LANES-1:0]          ld_lane,
    output irq_cmd_t                  cmd,
    output logic [DATA_W-1:0]         bus_rdata
);

    localparam int LANE_W = ADDR_W - 2;

    logic [LANE_W-1:0] lane_sel;
    logic [1:0]        sub_sel;
    logic [DATA_W-1:0] rd_mux;

    assign lane_sel = bus_addr[ADDR_W-1:2];
    assign sub_sel  = bus_addr[1:0];

    // Output latch load strobes, one per lane
    for (genvar k = 0; k < LANES; k++) begin : g_ld
        assign ld_lane[k] = bus_wr && (sub_sel == SUB_OUT)
                            && (lane_sel == LANE_W'(k));
    end

    // Interrupt side effects live only in lane group 0
    always_comb begin
        cmd.arm    = bus_rd && (lane_sel == '0) && (sub_sel == SUB_CTRL);
        cmd.disarm = bus_wr && (lane_sel == '0) && (sub_sel == SUB_CTRL);
        cmd.ack    = bus_wr && (lane_sel == '0) && (sub_sel == SUB_IN);
    end

    // Read mux: only input bytes return data, everything else reads zero
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < LANES; k++) begin
            if (bus_rd && (sub_sel == SUB_IN) && (lane_sel == LANE_W'(k))) begin
                rd_mux = in_sync[k*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/dio_in_sync.sv
module dio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] in_sync,
    output logic             chg_any
);

    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
            prev <= '0;
        end else begin
            stg[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign in_sync = stg[STAGES-1];
    // Both edges on any line count as a change
    assign chg_any = |(stg[STAGES-1] ^ prev);

endmodule

// File: rtl/dio_irq_fsm.sv
module dio_irq_fsm
    import dio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_cmd_t cmd,
    input  logic     chg_any,
    output logic     irq_req
);

    irq_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cmd.arm) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (chg_any) state_n = ST_PENDING;
            end
            ST_PENDING: begin
                // a fresh change outranks the acknowledge
                if (cmd.ack && !chg_any) state_n = ST_ARMED;
            end
            default: state_n = ST_OFF;
        endcase
        if (cmd.disarm) state_n = ST_OFF;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
        end else begin
            irq_req <= (state_n == ST_PENDING);
        end
    end

endmodule

// File: rtl/dio_out_latch.sv
module dio_out_latch #(
    parameter int              DATA_W    = 8,
    parameter int              LANES     = 2,
    parameter logic [DATA_W-1:0] RESET_VAL = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        ld_lane,
    input  logic [DATA_W-1:0]       wdata,
    output logic [LANES*DATA_W-1:0] drive_out
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                drive_out[k*DATA_W +: DATA_W] <= RESET_VAL;
            end else if (ld_lane[k]) begin
                drive_out[k*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dio_port_ctrl.sv
module dio_port_ctrl
    import dio_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 3,
    parameter int                LANES       = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] OUT_RESET   = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [LANES*DATA_W-1:0] pin_in,
    output logic [LANES*DATA_W-1:0] drive_out,
    output logic                    irq_req
);

    localparam int IO_W = LANES * DATA_W;

    logic [IO_W-1:0]  in_sync;
    logic             chg_any;
    logic [LANES-1:0] ld_lane;
    irq_cmd_t         cmd;

    dio_in_sync #(.WIDTH(IO_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .in_sync (in_sync),
        .chg_any (chg_any)
    );

    dio_bus_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .in_sync   (in_sync),
        .ld_lane   (ld_lane),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    dio_out_latch #(.DATA_W(DATA_W), .LANES(LANES), .RESET_VAL(OUT_RESET)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_lane   (ld_lane),
        .wdata     (bus_wdata),
        .drive_out (drive_out)
    );

    dio_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .chg_any (chg_any),
        .irq_req (irq_req)
    );

endmodule

// File: rtl/dio_port_ctrl_chk.sv
module dio_port_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [DATA_W-1:0]       bus_wdata,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [DATA_W-1:0]       bus_rdata,
    input logic [LANES*DATA_W-1:0] drive_out,
    input logic                    irq_req,
    input logic                    chg_any
);

    localparam int IO_W = LANES * DATA_W;

    logic spare_wr, zero_rd;
    assign spare_wr = bus_wr && (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(5)
                      || bus_addr == ADDR_W'(6) || bus_addr == ADDR_W'(7));
    assign zero_rd  = bus_rd && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(2)
                      || bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(4)
                      || bus_addr == ADDR_W'(6) || bus_addr == ADDR_W'(7));

    assert_lo_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> drive_out[DATA_W-1:0] == $past(bus_wdata));

    assert_hi_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=> drive_out[IO_W-1:IO_W-DATA_W] == $past(bus_wdata));

    assert_spare_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spare_wr |=> $stable(drive_out));

    assert_zero_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rd |=> bus_rdata == '0);

    assert_idle_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

    assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(chg_any));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1) && !chg_any) |=> !irq_req);

    assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(2)) |=> !irq_req);

    assert_change_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && chg_any && bus_wr && bus_addr == ADDR_W'(1)) |=> irq_req);

endmodule

bind dio_port_ctrl dio_port_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .drive_out (drive_out),
    .irq_req   (irq_req),
    .chg_any   (chg_any)
);

// File: tb/dio_port_ctrl_test.sv
module dio_port_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] drive_out;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } rd_item_t;
    rd_item_t rd_q[$];
    event     rd_done;

    always #2 clk = ~clk;

    dio_port_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .drive_out (drive_out),
        .irq_req   (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected byte, monitor compares when data is valid
    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.tag = tag; it.exp = exp;
        rd_q.push_back(it);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        -> rd_done;
        #0;
    endtask

    always @(rd_done) begin
        rd_item_t it;
        if (rd_q.size() == 0) begin
            check("scoreboard underrun", 32'd1, 32'd0);
        end else begin
            it = rd_q.pop_front();
            check(it.tag, {24'd0, bus_rdata}, {24'd0, it.exp});
        end
    end

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        check("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 outputs", {16'd0, drive_out}, 32'h0000FFFF);
        check("R1 irq", {31'd0, irq_req}, 32'd0);
        check("R1 rdata", {24'd0, bus_rdata}, 32'd0);

        // R2 output latches
        bus_write(3'd0, 8'h5A);
        check("R2 low byte", {16'd0, drive_out}, 32'h0000FF5A);
        bus_write(3'd4, 8'h3C);
        check("R2 high byte", {16'd0, drive_out}, 32'h00003C5A);

        // R4 spare writes and zero reads
        bus_write(3'd3, 8'h00);
        bus_write(3'd5, 8'h11);
        bus_write(3'd6, 8'h22);
        bus_write(3'd7, 8'h33);
        check("R4 spare writes keep outputs", {16'd0, drive_out}, 32'h00003C5A);
        bus_read(3'd0, 8'h00, "R4 read off0");
        bus_read(3'd4, 8'h00, "R4 read off4");
        bus_read(3'd3, 8'h00, "R4 read off3");
        bus_read(3'd6, 8'h00, "R4 read off6");
        bus_read(3'd7, 8'h00, "R4 read off7");

        // R3 inputs
        set_pins(16'hA5C3);
        idle(3);
        bus_read(3'd1, 8'hC3, "R3 input low");
        bus_read(3'd5, 8'hA5, "R3 input high");
        idle(1);
        check("R3 rdata idle zero", {24'd0, bus_rdata}, 32'd0);

        // R8 changes while disarmed are ignored
        set_pins(16'h0F0F);
        idle(5);
        check("R8 disarmed change ignored", {31'd0, irq_req}, 32'd0);

        // R5 arm by read, R6 latency and hold
        bus_read(3'd2, 8'h00, "R5 arm read data");
        idle(2);
        check("R5 armed no change", {31'd0, irq_req}, 32'd0);
        set_pins(16'h0F07);            // falling on line 3
        @(negedge clk);
        @(negedge clk);
        check("R6 not yet at edge 2", {31'd0, irq_req}, 32'd0);
        @(negedge clk);
        check("R6 raised at edge 3", {31'd0, irq_req}, 32'd1);
        idle(5);
        check("R6 held", {31'd0, irq_req}, 32'd1);

        // R4 spare write leaves pending request
        bus_write(3'd6, 8'hFF);
        check("R4 spare write keeps irq", {31'd0, irq_req}, 32'd1);
        bus_write(3'd5, 8'hFF);
        check("R4 high-input write keeps irq", {31'd0, irq_req}, 32'd1);

        // R5 second arm read leaves pending request
        bus_read(3'd2, 8'h00, "R5 rearm read data");
        check("R5 rearm keeps pending", {31'd0, irq_req}, 32'd1);

        // R7 acknowledge
        bus_write(3'd1, 8'hA7);
        check("R7 ack clears", {31'd0, irq_req}, 32'd0);
        set_pins(16'h1F07);            // rising on line 12
        idle(4);
        check("R7 still armed after ack", {31'd0, irq_req}, 32'd1);

        // R9 change coincides with ack
        set_pins(16'h1E07);
        @(negedge clk);
        bus_write(3'd1, 8'h00);
        check("R9 change beats ack", {31'd0, irq_req}, 32'd1);
        idle(2);
        bus_write(3'd1, 8'h00);
        check("R9 later ack clears", {31'd0, irq_req}, 32'd0);

        // R8 disarm clears pending, then ignores changes
        set_pins(16'h1E06);
        idle(4);
        check("R8 pending before disarm", {31'd0, irq_req}, 32'd1);
        bus_write(3'd2, 8'h00);
        check("R8 disarm clears", {31'd0, irq_req}, 32'd0);
        set_pins(16'hFFFF);
        idle(5);
        check("R8 change while disarmed", {31'd0, irq_req}, 32'd0);
        bus_read(3'd5, 8'hFF, "R3 high after change");
        bus_read(3'd2, 8'h00, "R5 arm again");
        idle(3);
        check("R5 no stale pending on rearm", {31'd0, irq_req}, 32'd0);
        set_pins(16'h7FFF);
        idle(4);
        check("R6 change after rearm", {31'd0, irq_req}, 32'd1);
        check("R2 outputs untouched by irq traffic", {16'd0, drive_out}, 32'h00003C5A);

        idle(2);
        finish_run();
    end

endmodule